// File: doc/BRIEF.md
# ISA I/O Strobe Generator

This block sits between a two-phase 8-bit microprocessor bus and an 8-bit ISA I/O slot. It turns the CPU's phase-2 clock, its read/write line and an active-low I/O select into the active-low ISA I/O write and I/O read strobes. All three inputs are asynchronous to the block. Each passes through a two-flop synchronizer and is then sampled on a fast system clock.

The ISA card captures write data when the write strobe falls. Data and address from the CPU settle only some time after phase 2 rises, so the strobe's falling edge is held back by a programmable number of system-clock cycles. This applies to both reads and writes. The strobe's rising edge follows the fall of phase 2 with no extra delay, so the strobe is narrower than phase 2 and never extends past the CPU cycle. If select goes inactive, or phase 2 falls, before the delay has run out, that CPU cycle produces no strobe.

Top module: `isa_io_strobe_gen`

## Requirements
- R1: While reset is high, and on the first clock edge after it, both isa_iow_n and isa_ior_n are high.
- R2: When io_sel_n is low and rw_in is low (write) during a phase-2 high phase that lasts H clock edges, isa_iow_n is low for exactly max(0, H - DELAY_CYCLES) cycles and isa_ior_n stays high.
- R3: When io_sel_n is low and rw_in is high (read) during such a phase, isa_ior_n is low for exactly max(0, H - DELAY_CYCLES) cycles and isa_iow_n stays high.
- R4: Once phi2_in is first sampled high by clock edge 1, a strobe that fires first reads low after clock edge DELAY_CYCLES + 3. This covers 2 synchronizer stages, DELAY_CYCLES counter steps and 1 output register.
- R5: Once phi2_in is last sampled high at edge H, the strobe is high again after edge H + 3. It is never held past the end of phase 2.
- R6: When io_sel_n is high (inactive) for the whole phase, both strobes stay high whatever rw_in and phase 2 do.
- R7: A phase-2 high phase of H <= DELAY_CYCLES edges produces no strobe.
- R8: If io_sel_n goes high while phase 2 is high and comes back low before the delay has expired, no strobe is produced for the rest of that phase.
- R9: isa_iow_n and isa_ior_n are never low at the same time.
- R10: The delay counter restarts from zero in every phase. Back-to-back phases separated by a 2-edge low gap each show the full delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| phi2_in | input | 1 | CPU phase-2 clock, asynchronous |
| rw_in | input | 1 | CPU read/write line, 1 = read, 0 = write, asynchronous |
| io_sel_n | input | 1 | Active-low I/O block select, asynchronous |
| isa_iow_n | output | 1 | Active-low ISA I/O write strobe, registered |
| isa_ior_n | output | 1 | Active-low ISA I/O read strobe, registered |

## Verification
The bench runs with a small delay so it can sweep every phase-2 high length from one edge up to several edges past the delay. Each length is tried with both directions and both select levels. The count of low cycles, computed as max(0, H - DELAY_CYCLES), separates a correct delay from an off-by-one. The first low edge shows whether the synchronizer and register stages are counted right, and checking the opposite strobe catches swapped direction gating. Separate patterns cover the following:
- a select that drops and returns before the delay expires, which shows the abort is held for the rest of the phase;
- phases only two edges apart, which show the counter clears between cycles.

// File: rtl/isa_strobe_pkg.sv
package isa_strobe_pkg;

  // bit positions inside the synchronized control bundle
  localparam int unsigned CTL_PHI2 = 0;
  localparam int unsigned CTL_RW   = 1;
  localparam int unsigned CTL_SELN = 2;
  localparam int unsigned CTL_W    = 3;

  // idle value of each raw input: phase 2 low, read, deselected
  localparam logic [CTL_W-1:0] CTL_IDLE = 3'b110;

  typedef struct packed {
    logic phi2;
    logic rd;
    logic sel;
  } bus_ctl_t;

  function automatic bus_ctl_t unpack_ctl(input logic [CTL_W-1:0] v);
    bus_ctl_t c;
    c.phi2 = v[CTL_PHI2];
    c.rd   = v[CTL_RW];
    c.sel  = ~v[CTL_SELN];
    return c;
  endfunction

endpackage

// File: rtl/ctl_sync_bank.sv
module ctl_sync_bank #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL[b]}};
        else     chain <= {chain[STAGES-2:0], async_in[b]};
      end
      assign sync_out[b] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/lead_delay_ctr.sv
module lead_delay_ctr #(
  parameter int unsigned DELAY_CYCLES = 19
) (
  input  logic clk,
  input  logic rst,
  input  logic phi2_s,
  output logic delay_done
);

  localparam int unsigned CNT_W = $clog2(DELAY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DELAY_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !phi2_s)      cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign delay_done = (cnt == CNT_MAX);

  // R10
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !phi2_s |=> (cnt == '0));

endmodule

// File: rtl/strobe_out.sv
module strobe_out (
  input  logic clk,
  input  logic rst,
  input  logic phi2_s,
  input  logic rd_s,
  input  logic sel_s,
  input  logic delay_done,
  output logic iow_n,
  output logic ior_n
);

  logic qual;
  logic fire;

  // qual: select has stayed active for the whole high phase so far
  always_ff @(posedge clk) begin
    if (rst || !phi2_s) qual <= 1'b1;
    else if (!sel_s)    qual <= 1'b0;
  end

  assign fire = qual & sel_s & phi2_s & delay_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      iow_n <= 1'b1;
      ior_n <= 1'b1;
    end else begin
      iow_n <= ~(fire & ~rd_s);
      ior_n <= ~(fire &  rd_s);
    end
  end

  // R1
  rst_idle_chk: assert property (@(posedge clk)
    rst |=> (iow_n && ior_n));

  // R4
  lead_edge_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(iow_n) || $fell(ior_n)) |-> $past(delay_done));

  // R5
  trail_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !phi2_s |=> (iow_n && ior_n));

  // R6
  desel_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_s |=> (iow_n && ior_n));

endmodule

// File: rtl/isa_io_strobe_gen.sv
module isa_io_strobe_gen
  import isa_strobe_pkg::*;
#(
  parameter int unsigned DELAY_CYCLES = 19,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic phi2_in,
  input  logic rw_in,
  input  logic io_sel_n,
  output logic isa_iow_n,
  output logic isa_ior_n
);

  logic [CTL_W-1:0] raw_ctl;
  logic [CTL_W-1:0] sync_ctl;
  bus_ctl_t         ctl;
  logic             delay_done;

  always_comb begin
    raw_ctl           = '0;
    raw_ctl[CTL_PHI2] = phi2_in;
    raw_ctl[CTL_RW]   = rw_in;
    raw_ctl[CTL_SELN] = io_sel_n;
  end

  ctl_sync_bank #(
    .WIDTH   (CTL_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (CTL_IDLE)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (raw_ctl),
    .sync_out (sync_ctl)
  );

  assign ctl = unpack_ctl(sync_ctl);

  lead_delay_ctr #(
    .DELAY_CYCLES (DELAY_CYCLES)
  ) u_delay (
    .clk        (clk),
    .rst        (rst),
    .phi2_s     (ctl.phi2),
    .delay_done (delay_done)
  );

  strobe_out u_out (
    .clk        (clk),
    .rst        (rst),
    .phi2_s     (ctl.phi2),
    .rd_s       (ctl.rd),
    .sel_s      (ctl.sel),
    .delay_done (delay_done),
    .iow_n      (isa_iow_n),
    .ior_n      (isa_ior_n)
  );

endmodule

// File: tb/tb_isa_io_strobe_gen.sv
module tb_isa_io_strobe_gen;

  localparam int unsigned D = 4;
  localparam int unsigned WATCHDOG = 50000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phi2_in = 1'b0;
  logic rw_in = 1'b1;
  logic io_sel_n = 1'b1;
  logic isa_iow_n;
  logic isa_ior_n;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  isa_io_strobe_gen #(.DELAY_CYCLES(D)) dut (
    .clk       (clk),
    .rst       (rst),
    .phi2_in   (phi2_in),
    .rw_in     (rw_in),
    .io_sel_n  (io_sel_n),
    .isa_iow_n (isa_iow_n),
    .isa_ior_n (isa_ior_n)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One phase: select/direction set, 3 low edges, then H high edges and L low edges.
  // abort=1 deasserts select after edge 2 and restores it after edge 4.
  task automatic run_phase(input int h, input int l, input bit rd, input bit sel,
                           input bit abort, input bit checked);
    int low_w = 0, low_r = 0, first = 0, last = 0, both = 0;
    int exp_n;
    @(negedge clk);
    rw_in = rd;
    io_sel_n = ~sel;
    repeat (3) @(negedge clk);
    phi2_in = 1'b1;
    for (int k = 1; k <= h + l; k++) begin
      @(negedge clk);
      if (!isa_iow_n) low_w++;
      if (!isa_ior_n) low_r++;
      if (!isa_iow_n && !isa_ior_n) both++;
      if (!isa_iow_n || !isa_ior_n) begin
        if (first == 0) first = k;
        last = k;
      end
      if (k == h) phi2_in = 1'b0;
      if (abort && k == 2) io_sel_n = 1'b1;
      if (abort && k == 4) io_sel_n = 1'b0;
    end
    if (!checked) return;
    exp_n = (sel && !abort && h > D) ? h - D : 0;
    // R2 R3 R6 R7 R8: low-cycle counts
    if (rd) begin
      chk(abort ? "R8" : (!sel ? "R6" : (h <= D ? "R7" : "R3")), low_r, exp_n);
      chk("R3 iow idle on read", low_w, 0);
    end else begin
      chk(abort ? "R8" : (!sel ? "R6" : (h <= D ? "R7" : "R2")), low_w, exp_n);
      chk("R2 ior idle on write", low_r, 0);
    end
    chk("R9 never both low", both, 0);
    if (exp_n > 0) begin
      chk("R4 first low edge", first, D + 3);
      chk("R5 last low edge", last, h + 2);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset holds both strobes high
    chk("R1 iow in reset", isa_iow_n, 1);
    chk("R1 ior in reset", isa_ior_n, 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 iow after reset", isa_iow_n, 1);
    chk("R1 ior after reset", isa_ior_n, 1);

    // sweep of high length, direction, select
    for (int h = 1; h <= D + 5; h++)
      for (int rd = 0; rd < 2; rd++)
        for (int s = 0; s < 2; s++)
          run_phase(h, 4, rd[0], s[0], 1'b0, 1'b1);

    // R8: select glitch before delay expiry
    run_phase(D + 6, 4, 1'b0, 1'b1, 1'b1, 1'b1);
    run_phase(D + 6, 4, 1'b1, 1'b1, 1'b1, 1'b1);

    // R10: back-to-back phases with a 2-edge low gap
    run_phase(D + 3, 2, 1'b0, 1'b1, 1'b0, 1'b1);
    phi2_in = 1'b1;
    begin
      int first = 0, cnt = 0;
      for (int k = 1; k <= D + 7; k++) begin
        @(negedge clk);
        if (!isa_iow_n) begin
          cnt++;
          if (first == 0) first = k;
        end
        if (k == D + 3) phi2_in = 1'b0;
      end
      chk("R10 second phase first low", first, D + 3);
      chk("R10 second phase width", cnt, 3);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule